// File: doc/BRIEF.md
# Command-Stepped I2C Target Engine

This block is the bus side of an I2C target (slave) that takes no decision of its own. Software picks an operation code and pulses a trigger. The engine then carries out exactly one bus phase and stops. The phase can be a wait for a start condition, a received byte, a sent byte followed by the controller's acknowledge, or one acknowledge bit driven by the target. At the end of the phase the engine clears its busy flag, leaves a status code and raises an interrupt. Software reads the result and chooses the next step. Address comparison, combining a 10-bit address from two bytes, clock stretching and arbitration are all left to software.

The SCL and SDA pins are sampled through a two-flop synchronizer, and edges are found on the synchronized levels. A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. The engine drives SDA only as an open-drain low through `sda_oe_o`, and only during a commanded bit phase.

In a typical target-read transfer, software issues these steps in order:
1. Wait for start.
2. Receive the first byte (with a 7-bit address, this holds the address and the direction bit, 1 meaning read).
3. Acknowledge.
4. Send bytes until the controller answers with a NAK.
5. Issue a receive that ends on the controller's stop.

Top module: `i2c_cmd_slave`

## Requirements
- R1: After reset, `busy_o`, `irq_o` and `sda_oe_o` are 0, `status_o` is 0 and `rx_byte_o` is 0.
- R2: When the engine is idle and accepts a trigger, `busy_o` is 1 from the cycle after the trigger until the phase completes. A trigger given while `busy_o` is 1 is ignored.
- R3: Operation code 0 waits for a start condition (SDA falls while SCL is high) and then completes with status 0. Code 0 is accepted at any time the engine is idle. A stop condition during this wait does not end it.
- R4: Codes 2, 3, 4 and 5 are refused (`busy_o` stays 0) until a start condition has been seen, and again after a stop condition. Codes 1, 6 and 7 are always refused.
- R5: Code 3 shifts in SDA on each of 8 SCL rising edges, MSB first. It then loads the byte into `rx_byte_o` and completes with status 3. `rx_byte_o` changes at no other time. For an address byte, bit 0 is the direction bit.
- R6: Code 2 places the bits of `tx_byte_i` (captured at the trigger) on SDA, MSB first, each while SCL is low. After the 8th SCL falling edge it releases SDA and samples SDA at the next SCL rising edge. A low level completes with status 2 (acknowledged, transmit empty); a high level completes with status 1 (NAK received).
- R7: Code 4 pulls SDA low from the first SCL-low level until the SCL falling edge that follows the next rising edge. Code 5 keeps SDA released over the same bit. Both complete with status 6.
- R8: A stop condition during a code 2, 3, 4 or 5 phase ends that phase with status 5 and disarms the engine.
- R9: A start condition during a code 2, 3, 4 or 5 phase (repeated start) ends that phase with status 0. `rx_byte_o` is left unchanged.
- R10: Every completion sets `irq_o`. A one-cycle pulse on `irq_clr_i` clears it. If a completion and a clear fall in the same cycle, the completion wins.
- R11: `sda_oe_o` is 0 whenever `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level (wired bus value) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| mode_i | input | 3 | Operation code taken at the trigger |
| trig_i | input | 1 | One-cycle trigger strobe |
| tx_byte_i | input | DATA_W | Byte to send, captured at a code 2 trigger |
| irq_clr_i | input | 1 | Write-1 pulse clearing the interrupt |
| busy_o | output | 1 | Phase in progress |
| status_o | output | 3 | Result code of the last phase |
| rx_byte_o | output | DATA_W | Receive buffer |
| irq_o | output | 1 | Completion interrupt |

## Verification
A wrong phase or bit count inside the engine shows up on the bus within one SCL bit. The shape of the error depends on where it sits:
- In a send, a wrong bit count or shift order produces a byte that differs from `tx_byte_i`.
- In a receive, the same fault leaves a wrong value in `rx_byte_o`.
- In an acknowledge, it leaves SDA at the wrong level.

The scoreboard compares every completion against the status code, receive byte and interrupt expected for that step. A stuck busy state or a missed start or stop therefore appears as a missing completion, or as a completion with the wrong code. A lost arm flag shows up immediately: the next trigger is either accepted or refused against the rule in R4.

// File: rtl/i2c_cs_pkg.sv
package i2c_cs_pkg;

    typedef enum logic [2:0] {
        MODE_START = 3'd0,
        MODE_TX    = 3'd2,
        MODE_RX    = 3'd3,
        MODE_ACK   = 3'd4,
        MODE_NAK   = 3'd5
    } cmd_mode_e;

    typedef enum logic [2:0] {
        ST_START     = 3'd0,
        ST_NAK_RX    = 3'd1,
        ST_TX_EMPTY  = 3'd2,
        ST_RX_FULL   = 3'd3,
        ST_STOP      = 3'd5,
        ST_ACK_SENT  = 3'd6
    } stat_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT_START,
        PH_RX,
        PH_TX,
        PH_TX_ACK,
        PH_ACK_BIT
    } phase_e;

    // synchronized view of one bus line
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_ev_t;

    // codes that need an armed bus (start already seen)
    function automatic logic is_bus_mode(input logic [2:0] m);
        return (m == MODE_TX) || (m == MODE_RX) || (m == MODE_ACK) || (m == MODE_NAK);
    endfunction

    // acknowledge slot result: low level means acknowledged
    function automatic stat_e ack_status(input logic sda_level);
        return sda_level ? ST_NAK_RX : ST_TX_EMPTY;
    endfunction

endpackage

// File: rtl/i2c_cs_line_sync.sv
module i2c_cs_line_sync
    import i2c_cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_i,
    output line_ev_t ev_o
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // idle bus level is high, so reset to 1 to avoid a false edge
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= pin_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], pin_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[STAGES-1];
    end

    assign ev_o.level = chain[STAGES-1];
    assign ev_o.rise  = chain[STAGES-1] & ~prev;
    assign ev_o.fall  = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/i2c_cs_shreg.sv
module i2c_cs_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] value_o
);

    always_ff @(posedge clk) begin
        if (rst)          value_o <= '0;
        else if (load_i)  value_o <= load_val_i;
        else if (shift_i) value_o <= {value_o[DATA_W-2:0], bit_i};
    end

endmodule

// File: rtl/i2c_cs_ctrl.sv
module i2c_cs_ctrl
    import i2c_cs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          scl_i,
    input  line_ev_t          sda_i,
    input  logic [2:0]        mode_i,
    input  logic              trig_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              irq_clr_i,
    input  logic [DATA_W-1:0] sh_value_i,
    output logic              sh_load_o,
    output logic [DATA_W-1:0] sh_load_val_o,
    output logic              sh_shift_o,
    output logic              sh_bit_o,
    output logic              busy_o,
    output logic [2:0]        status_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              irq_o,
    output logic              sda_oe_o,
    output logic              armed_o
);

    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    phase_e          ph;
    stat_e           status;
    logic [CNT_W-1:0] cnt;
    logic            got_low;
    logic            got_rise;
    logic            drive_low;

    logic            start_det;
    logic            stop_det;
    logic            accept;
    logic            fin;
    stat_e           fin_st;
    logic            rx_load;

    assign start_det = scl_i.level & sda_i.fall;
    assign stop_det  = scl_i.level & sda_i.rise;
    assign accept    = (mode_i == MODE_START) || (armed_o && is_bus_mode(mode_i));

    // completion decision
    always_comb begin
        fin     = 1'b0;
        fin_st  = ST_START;
        rx_load = 1'b0;
        unique case (ph)
            PH_WAIT_START: begin
                if (start_det) fin = 1'b1;
            end
            PH_RX, PH_TX, PH_TX_ACK, PH_ACK_BIT: begin
                if (start_det) begin
                    fin    = 1'b1;
                    fin_st = ST_START;
                end else if (stop_det) begin
                    fin    = 1'b1;
                    fin_st = ST_STOP;
                end else if (ph == PH_RX) begin
                    if (scl_i.rise && cnt == LAST) begin
                        fin     = 1'b1;
                        fin_st  = ST_RX_FULL;
                        rx_load = 1'b1;
                    end
                end else if (ph == PH_TX_ACK) begin
                    if (scl_i.rise) begin
                        fin    = 1'b1;
                        fin_st = ack_status(sda_i.level);
                    end
                end else if (ph == PH_ACK_BIT) begin
                    if (got_low && got_rise && scl_i.fall) begin
                        fin    = 1'b1;
                        fin_st = ST_ACK_SENT;
                    end
                end
            end
            default: ;
        endcase
    end

    // shift register control
    always_comb begin
        sh_load_o     = 1'b0;
        sh_load_val_o = tx_byte_i;
        sh_shift_o    = 1'b0;
        sh_bit_o      = 1'b0;
        if (ph == PH_IDLE && trig_i && accept && mode_i == MODE_TX)
            sh_load_o = 1'b1;
        if (ph == PH_RX && !start_det && !stop_det && scl_i.rise) begin
            sh_shift_o = 1'b1;
            sh_bit_o   = sda_i.level;
        end
        if (ph == PH_TX && !start_det && !stop_det && got_low && got_rise && scl_i.fall)
            sh_shift_o = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            status    <= ST_START;
            cnt       <= '0;
            got_low   <= 1'b0;
            got_rise  <= 1'b0;
            drive_low <= 1'b0;
            busy_o    <= 1'b0;
            irq_o     <= 1'b0;
            sda_oe_o  <= 1'b0;
            armed_o   <= 1'b0;
            rx_byte_o <= '0;
        end else begin
            if (start_det)     armed_o <= 1'b1;
            else if (stop_det) armed_o <= 1'b0;

            if (irq_clr_i) irq_o <= 1'b0;

            if (fin) begin
                ph       <= PH_IDLE;
                busy_o   <= 1'b0;
                status   <= fin_st;
                irq_o    <= 1'b1;
                sda_oe_o <= 1'b0;
                if (rx_load) rx_byte_o <= {sh_value_i[DATA_W-2:0], sda_i.level};
            end else begin
                unique case (ph)
                    PH_IDLE: begin
                        if (trig_i && accept) begin
                            busy_o    <= 1'b1;
                            cnt       <= '0;
                            got_low   <= 1'b0;
                            got_rise  <= 1'b0;
                            drive_low <= (mode_i == MODE_ACK);
                            unique case (mode_i)
                                MODE_START: ph <= PH_WAIT_START;
                                MODE_RX:    ph <= PH_RX;
                                MODE_TX:    ph <= PH_TX;
                                default:    ph <= PH_ACK_BIT;
                            endcase
                        end
                    end
                    PH_RX: begin
                        if (scl_i.rise) cnt <= cnt + 1'b1;
                    end
                    PH_TX: begin
                        if (!got_low) begin
                            if (!scl_i.level) begin
                                got_low  <= 1'b1;
                                sda_oe_o <= ~sh_value_i[DATA_W-1];
                            end
                        end else begin
                            if (scl_i.rise) got_rise <= 1'b1;
                            if (scl_i.fall && got_rise) begin
                                got_rise <= 1'b0;
                                if (cnt == LAST) begin
                                    sda_oe_o <= 1'b0;
                                    ph       <= PH_TX_ACK;
                                end else begin
                                    cnt      <= cnt + 1'b1;
                                    sda_oe_o <= ~sh_value_i[DATA_W-2];
                                end
                            end
                        end
                    end
                    PH_ACK_BIT: begin
                        if (!got_low) begin
                            if (!scl_i.level) begin
                                got_low  <= 1'b1;
                                sda_oe_o <= drive_low;
                            end
                        end else if (scl_i.rise) begin
                            got_rise <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign status_o = status;

endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave
    import i2c_cs_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        mode_i,
    input  logic              trig_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              irq_clr_i,
    output logic              busy_o,
    output logic [2:0]        status_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              irq_o
);

    line_ev_t          scl_ev;
    line_ev_t          sda_ev;
    logic              sh_load;
    logic [DATA_W-1:0] sh_load_val;
    logic              sh_shift;
    logic              sh_bit;
    logic [DATA_W-1:0] sh_value;
    logic              armed;

    i2c_cs_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_i (scl_i),
        .ev_o  (scl_ev)
    );

    i2c_cs_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_i (sda_i),
        .ev_o  (sda_ev)
    );

    i2c_cs_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk        (clk),
        .rst        (rst),
        .load_i     (sh_load),
        .load_val_i (sh_load_val),
        .shift_i    (sh_shift),
        .bit_i      (sh_bit),
        .value_o    (sh_value)
    );

    i2c_cs_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl_ev),
        .sda_i         (sda_ev),
        .mode_i        (mode_i),
        .trig_i        (trig_i),
        .tx_byte_i     (tx_byte_i),
        .irq_clr_i     (irq_clr_i),
        .sh_value_i    (sh_value),
        .sh_load_o     (sh_load),
        .sh_load_val_o (sh_load_val),
        .sh_shift_o    (sh_shift),
        .sh_bit_o      (sh_bit),
        .busy_o        (busy_o),
        .status_o      (status_o),
        .rx_byte_o     (rx_byte_o),
        .irq_o         (irq_o),
        .sda_oe_o      (sda_oe_o),
        .armed_o       (armed)
    );

endmodule

// File: rtl/i2c_cs_checker.sv
module i2c_cs_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              trig_i,
    input logic [2:0]        mode_i,
    input logic              irq_clr_i,
    input logic              busy_o,
    input logic [2:0]        status_o,
    input logic [DATA_W-1:0] rx_byte_o,
    input logic              irq_o,
    input logic              sda_oe_o,
    input logic              armed
);

    // R2: an accepted trigger raises busy on the next cycle
    a_r2_busy_on_trig: assert property (@(posedge clk) disable iff (rst)
        (trig_i && !busy_o && (mode_i == 3'd0 ||
         (armed && (mode_i == 3'd2 || mode_i == 3'd3 || mode_i == 3'd4 || mode_i == 3'd5))))
        |=> busy_o);

    // R4: bus codes are refused while not armed
    a_r4_refuse_unarmed: assert property (@(posedge clk) disable iff (rst)
        (trig_i && !busy_o && !armed && mode_i != 3'd0) |=> !busy_o);

    // R4: unassigned codes are always refused
    a_r4_refuse_bad_code: assert property (@(posedge clk) disable iff (rst)
        (trig_i && !busy_o && (mode_i == 3'd1 || mode_i == 3'd6 || mode_i == 3'd7)) |=> !busy_o);

    // R3: every completion leaves a defined status code
    a_r3_status_legal: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (status_o != 3'd4 && status_o != 3'd7));

    // R5: receive buffer only changes on a receive completion
    a_r5_rx_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_byte_o) |-> (status_o == 3'd3 && !busy_o));

    // R10: a completion raises the interrupt
    a_r10_irq_on_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> irq_o);

    // R10: write-1 clear takes effect when no phase can complete
    a_r10_irq_clear: assert property (@(posedge clk) disable iff (rst)
        (irq_clr_i && !busy_o) |=> !irq_o);

    // R11: SDA is released whenever the engine is idle
    a_r11_release_idle: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !sda_oe_o);

endmodule

bind i2c_cmd_slave i2c_cs_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .trig_i    (trig_i),
    .mode_i    (mode_i),
    .irq_clr_i (irq_clr_i),
    .busy_o    (busy_o),
    .status_o  (status_o),
    .rx_byte_o (rx_byte_o),
    .irq_o     (irq_o),
    .sda_oe_o  (sda_oe_o),
    .armed     (armed)
);

// File: tb/sim_i2c_cmd_slave.sv
`timescale 1ns/1ps
module sim_i2c_cmd_slave;

    localparam int HALF = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [2:0] mode_r = 3'd0;
    logic       trig = 1'b0;
    logic [7:0] tx_r = 8'h00;
    logic       irq_clr = 1'b0;
    logic       busy;
    logic [2:0] status;
    logic [7:0] rx_byte;
    logic       irq;
    logic       sda_line;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done_flag = 1'b0;

    // scoreboard queues
    int    q_st[$];
    bit    q_chk[$];
    int    q_rx[$];
    string q_tag[$];

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2c_cmd_slave u0 (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe_o  (sda_oe),
        .mode_i    (mode_r),
        .trig_i    (trig),
        .tx_byte_i (tx_r),
        .irq_clr_i (irq_clr),
        .busy_o    (busy),
        .status_o  (status),
        .rx_byte_o (rx_byte),
        .irq_o     (irq)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic cmd(input logic [2:0] m, input logic [7:0] b);
        mode_r = m;
        tx_r   = b;
        trig   = 1'b1;
        tick(1);
        trig   = 1'b0;
    endtask

    task automatic clr_irq();
        irq_clr = 1'b1;
        tick(1);
        irq_clr = 1'b0;
    endtask

    task automatic expect_done(input int st, input bit chk, input int rxv, input string tag);
        q_st.push_back(st);
        q_chk.push_back(chk);
        q_rx.push_back(rxv);
        q_tag.push_back(tag);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 5000 && busy; k++) tick(1);
        tick(2);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b0; tick(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b1; tick(HALF);
    endtask

    task automatic wr_bit(input logic b);
        sda_m = b;    tick(HALF);
        scl_m = 1'b1; tick(HALF);
        scl_m = 1'b0; tick(HALF);
    endtask

    task automatic rd_bit(output logic b);
        sda_m = 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF / 2);
        b = sda_line; tick(HALF / 2);
        scl_m = 1'b0; tick(HALF);
    endtask

    task automatic wr_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) wr_bit(v[i]);
    endtask

    task automatic rd_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rd_bit(b);
            v[i] = b;
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // monitor: pops one expected item per completion
    logic pbusy = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            pbusy = 1'b0;
        end else begin
            if (pbusy && !busy) begin
                if (q_st.size() == 0) begin
                    check(1'b0, "R2", "unexpected completion status", status, 0);
                end else begin
                    int    est;
                    bit    ec;
                    int    erx;
                    string et;
                    est = q_st.pop_front();
                    ec  = q_chk.pop_front();
                    erx = q_rx.pop_front();
                    et  = q_tag.pop_front();
                    check(status == est[2:0], et, "status", status, est);
                    if (ec) check(rx_byte == erx[7:0], et, "rx_byte", rx_byte, erx);
                    check(irq == 1'b1, "R10", "irq on completion", irq, 1);
                end
            end
            pbusy = busy;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done_flag) begin
            fails++;
            $display("FAIL R2 watchdog expired actual=busy expected=idle");
            summary();
            $finish;
        end
    end

    initial begin
        logic       b;
        logic [7:0] v;

        tick(5);
        rst = 1'b0;
        tick(2);

        // R1 reset state
        check(busy == 0,     "R1", "busy",   busy, 0);
        check(status == 0,   "R1", "status", status, 0);
        check(irq == 0,      "R1", "irq",    irq, 0);
        check(sda_oe == 0,   "R1", "sda_oe", sda_oe, 0);
        check(rx_byte == 0,  "R1", "rx",     rx_byte, 0);

        // R4 receive refused before any start
        cmd(3'd3, 8'h00);
        check(busy == 0, "R4", "busy after unarmed rx", busy, 0);
        tick(2);
        check(irq == 0, "R4", "irq after refused", irq, 0);

        // R3 start wait, stop ignored, trigger while busy ignored (R2)
        cmd(3'd0, 8'h00);
        check(busy == 1, "R2", "busy after trigger", busy, 1);
        expect_done(0, 1'b1, 8'h00, "R3");
        scl_m = 1'b0; tick(HALF);
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b1; tick(HALF);
        check(busy == 1, "R3", "busy after stop during wait", busy, 1);
        cmd(3'd3, 8'h00);
        check(busy == 1, "R2", "busy after trigger while busy", busy, 1);
        bus_start();
        wait_idle();
        check(irq == 1, "R10", "irq set", irq, 1);
        clr_irq();
        tick(1);
        check(irq == 0, "R10", "irq cleared", irq, 0);

        // R5 address byte 0x52 with read direction
        cmd(3'd3, 8'h00);
        expect_done(3, 1'b1, 8'hA5, "R5");
        wr_byte(8'hA5);
        wait_idle();
        check(rx_byte[0] == 1'b1, "R5", "direction bit", rx_byte[0], 1);
        clr_irq();

        // R7 acknowledge drive
        cmd(3'd4, 8'h00);
        expect_done(6, 1'b0, 0, "R7");
        rd_bit(b);
        check(b == 1'b0, "R7", "ack level", b, 0);
        wait_idle();
        check(sda_oe == 0, "R11", "sda_oe idle", sda_oe, 0);
        clr_irq();

        // R6 send with acknowledge
        cmd(3'd2, 8'h3C);
        expect_done(2, 1'b0, 0, "R6");
        rd_byte(v);
        check(v == 8'h3C, "R6", "sent byte", v, 8'h3C);
        wr_bit(1'b0);
        wait_idle();
        clr_irq();

        // R6 send with NAK
        cmd(3'd2, 8'hC3);
        expect_done(1, 1'b0, 0, "R6");
        rd_byte(v);
        check(v == 8'hC3, "R6", "sent byte", v, 8'hC3);
        wr_bit(1'b1);
        wait_idle();
        clr_irq();

        // R8 stop during receive, buffer unchanged
        cmd(3'd3, 8'h00);
        expect_done(5, 1'b1, 8'hA5, "R8");
        bus_stop();
        wait_idle();
        clr_irq();
        cmd(3'd3, 8'h00);
        check(busy == 0, "R8", "refused after stop", busy, 0);

        // re-arm
        cmd(3'd0, 8'h00);
        expect_done(0, 1'b0, 0, "R3");
        bus_start();
        wait_idle();
        clr_irq();

        // R4 unassigned codes
        cmd(3'd7, 8'h00);
        check(busy == 0, "R4", "code 7 refused", busy, 0);
        cmd(3'd1, 8'h00);
        check(busy == 0, "R4", "code 1 refused", busy, 0);

        // R5 second pattern then R7 NAK drive
        cmd(3'd3, 8'h00);
        expect_done(3, 1'b1, 8'h3B, "R5");
        wr_byte(8'h3B);
        wait_idle();
        clr_irq();
        cmd(3'd5, 8'h00);
        expect_done(6, 1'b0, 0, "R7");
        rd_bit(b);
        check(b == 1'b1, "R7", "nak level", b, 1);
        wait_idle();
        clr_irq();

        // R9 repeated start during receive
        cmd(3'd3, 8'h00);
        expect_done(0, 1'b1, 8'h3B, "R9");
        wr_bit(1'b1);
        wr_bit(1'b0);
        bus_start();
        wait_idle();
        clr_irq();

        // R5 all-ones byte after repeated start keeps engine armed
        cmd(3'd3, 8'h00);
        expect_done(3, 1'b1, 8'hFF, "R5");
        wr_byte(8'hFF);
        wait_idle();
        clr_irq();

        tick(10);
        check(q_st.size() == 0, "R2", "pending completions", q_st.size(), 0);
        check(sda_oe == 0, "R11", "sda_oe at end", sda_oe, 0);

        done_flag = 1'b1;
        summary();
        $finish;
    end

endmodule